// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block builds the word a flash array returns on a read while an internal program or erase is running, or while an erase is suspended. It takes the current operation mode, the identity of the suspended sector, the read address, the true array word at that address and a read strobe. It passes the array word through, but replaces the polling bit (bit 7) and the two toggle bits (bits 6 and 2) according to the mode. Host software can then tell whether an operation is still running, has finished, or is suspended in the sector being read, and it can do this without any extra status register.

Each toggle bit is a flip-flop that inverts when the read strobe falls, provided its toggle condition holds during that read. After a program or erase finishes, the polling bit shows true data at once. The other bits are not yet valid, so the block drives them with the complement of the array data for a set number of clock cycles. The number comes from a parameter and is meant to span the settling time of the array.

Top module: `flash_status_gen`

## Requirements
- R1: After reset both toggle flip-flops hold 0 and no settle window is open, so a read in idle mode (op_mode = 0) returns the array word unchanged.
- R2: In program mode (op_mode = 1), bit 7 of rd_data is the complement of array bit 7, bit 2 equals array bit 2, and every bit other than 7 and 6 equals the array word.
- R3: In erase mode (op_mode = 2), bit 7 reads 0, bits 6 and 2 show the two toggle flip-flops, and all other bits equal the array word.
- R4: The bit-6 toggle flip-flop inverts at each falling edge of rd_strobe that occurs in program mode, in erase mode, or in suspend mode while susp_prog is high and the address lies outside the suspended sector. At every other falling edge it holds its value.
- R5: The bit-2 toggle flip-flop inverts at each falling edge of rd_strobe in erase mode, and in suspend mode when the address lies inside the suspended sector. It holds its value in program mode.
- R6: In suspend mode (op_mode = 3), a read whose sector number equals susp_sector returns bit 7 = 1, bit 6 = 1, and bit 2 from the toggle flip-flop. The sector number is the upper SECT_W bits of rd_addr.
- R7: In suspend mode, with susp_prog low, a read outside the suspended sector returns the array word unchanged and leaves both toggle flip-flops unchanged.
- R8: In suspend mode, with susp_prog high, a read outside the suspended sector returns bit 7 complemented, bit 6 from its toggle flip-flop, and all other bits, bit 2 included, from the array.
- R9: When the mode changes from program or erase to idle, a settle window opens at once and lasts SETTLE_CYCLES rising clock edges. During the window, bit 7 is true data and every other bit is the complement of the array word. After the window, reads are plain.
- R10: Toggle flip-flops keep their values across mode changes, so toggling resumes from the held value in the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_mode | input | 2 | 0 idle, 1 program, 2 erase, 3 erase suspended |
| susp_prog | input | 1 | Program running outside the suspended sector during suspend |
| susp_sector | input | SECT_W | Sector number of the suspended erase |
| rd_addr | input | ADDR_W | Read address; its upper SECT_W bits select the sector |
| rd_strobe | input | 1 | Read strobe, high while a read is active |
| array_data | input | DATA_W | True array word at rd_addr |
| rd_data | output | DATA_W | Word returned to the host |

## Verification
A wrong toggle flip-flop shows up at the very next read in a mode that routes that bit to rd_data. A flip missed or doubled in an earlier read stays wrong until another flip corrects it, so the bench follows the expected flip-flop values across long random read sequences in mixed modes. A wrong settle counter shows up as an inverted or non-inverted word on the first idle read after the window edge, so that edge is probed cycle by cycle. A wrong sector comparison shows up on the first suspend read that lands just inside or just outside the suspended sector.

// File: rtl/flash_status_pkg.sv
// Shared mode encoding and status bit positions for the flash status generator.
package flash_status_pkg;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_PROGRAM = 2'd1,
        OP_ERASE   = 2'd2,
        OP_SUSPEND = 2'd3
    } op_mode_e;

    localparam int POLL_BIT  = 7;
    localparam int TOG_A_BIT = 6;
    localparam int TOG_B_BIT = 2;
    localparam int NUM_TOG   = 2;

endpackage

// File: rtl/fsg_toggle_bit.sv
// One toggle flip-flop. It inverts on each read-strobe fall pulse while its
// condition is true. Assumes fall_pulse is a one-cycle pulse from the parent.
module fsg_toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_pulse,
    input  logic cond,
    output logic q
);
    logic fire;
    assign fire = fall_pulse && cond;

    // Invert the stored bit on each qualifying strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else if (fire) q <= ~q;
    end

    AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(q)); // R4
    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (q != $past(q))); // R5
endmodule

// File: rtl/fsg_settle_timer.sv
// Opens a settle window when the mode changes from program/erase to idle.
// The window lasts SETTLE_CYCLES clock edges. Assumes the mode is synchronous to clk.
module fsg_settle_timer #(
    parameter int SETTLE_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic idle,
    output logic active
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic             prev_busy;
    logic [CNT_W-1:0] cnt;

    // Remember whether the previous cycle held a running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_busy <= 1'b0;
        else        prev_busy <= busy;
    end

    // Load on completion, count down while idle, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!idle)         cnt <= '0;
        else if (prev_busy)     cnt <= CNT_W'(SETTLE_CYCLES);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign active = idle && (prev_busy || (cnt != '0));

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(SETTLE_CYCLES)); // R9
    AST_SETTLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_busy && idle) |=> (cnt == CNT_W'(SETTLE_CYCLES))); // R9
endmodule

// File: rtl/fsg_status_mux.sv
// Substitutes the polling and toggle bits into the array word for the mode.
// Purely combinational. Assumes in_sect and the toggle bits come from the parent.
module fsg_status_mux #(
    parameter int DATA_W = 16
) (
    input  flash_status_pkg::op_mode_e mode,
    input  logic              susp_prog,
    input  logic              in_sect,
    input  logic              settle,
    input  logic              tog_a,
    input  logic              tog_b,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    import flash_status_pkg::*;

    // Choose the returned word from mode, sector match and settle state.
    always_comb begin
        rd_data = array_data;
        case (mode)
            OP_PROGRAM: begin
                rd_data[POLL_BIT]  = ~array_data[POLL_BIT];
                rd_data[TOG_A_BIT] = tog_a;
            end
            OP_ERASE: begin
                rd_data[POLL_BIT]  = 1'b0;
                rd_data[TOG_A_BIT] = tog_a;
                rd_data[TOG_B_BIT] = tog_b;
            end
            OP_SUSPEND: begin
                if (in_sect) begin
                    rd_data[POLL_BIT]  = 1'b1;
                    rd_data[TOG_A_BIT] = 1'b1;
                    rd_data[TOG_B_BIT] = tog_b;
                end else if (susp_prog) begin
                    rd_data[POLL_BIT]  = ~array_data[POLL_BIT];
                    rd_data[TOG_A_BIT] = tog_a;
                end
            end
            default: begin
                if (settle) begin
                    rd_data           = ~array_data;
                    rd_data[POLL_BIT] = array_data[POLL_BIT];
                end
            end
        endcase
    end
endmodule

// File: rtl/flash_status_gen.sv
// Top of the status generator. It detects read-strobe falls, keeps the two
// toggle flip-flops, runs the settle timer and drives the status mux.
// Assumes all inputs are synchronous to clk and rd_addr is held through the strobe fall.
module flash_status_gen #(
    parameter int DATA_W        = 16,
    parameter int ADDR_W        = 20,
    parameter int SECT_W        = 8,
    parameter int SETTLE_CYCLES = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_mode,
    input  logic              susp_prog,
    input  logic [SECT_W-1:0] susp_sector,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    import flash_status_pkg::*;

    op_mode_e           mode;
    logic               strobe_q;
    logic               fall_pulse;
    logic               in_sect;
    logic               settle;
    logic [NUM_TOG-1:0] tog_cond;
    logic [NUM_TOG-1:0] tog_q;

    assign mode    = op_mode_e'(op_mode);
    assign in_sect = (rd_addr[ADDR_W-1 -: SECT_W] == susp_sector);

    // Delay the strobe by one cycle to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= rd_strobe;
    end
    assign fall_pulse = strobe_q && !rd_strobe;

    // Toggle conditions: index 0 drives bit 6, index 1 drives bit 2.
    always_comb begin
        tog_cond[0] = (mode == OP_PROGRAM) || (mode == OP_ERASE) ||
                      ((mode == OP_SUSPEND) && susp_prog && !in_sect);
        tog_cond[1] = (mode == OP_ERASE) || ((mode == OP_SUSPEND) && in_sect);
    end

    for (genvar gi = 0; gi < NUM_TOG; gi++) begin : g_tog
        fsg_toggle_bit u_tog (
            .clk        (clk),
            .rst_n      (rst_n),
            .fall_pulse (fall_pulse),
            .cond       (tog_cond[gi]),
            .q          (tog_q[gi])
        );
    end

    fsg_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   ((mode == OP_PROGRAM) || (mode == OP_ERASE)),
        .idle   (mode == OP_IDLE),
        .active (settle)
    );

    fsg_status_mux #(.DATA_W(DATA_W)) u_mux (
        .mode       (mode),
        .susp_prog  (susp_prog),
        .in_sect    (in_sect),
        .settle     (settle),
        .tog_a      (tog_q[0]),
        .tog_b      (tog_q[1]),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

    AST_PROG_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OP_PROGRAM) |-> (rd_data[POLL_BIT] != array_data[POLL_BIT])); // R2
    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OP_ERASE) |-> !rd_data[POLL_BIT]); // R3
    AST_SUSP_SECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == OP_SUSPEND) && in_sect) |-> (rd_data[POLL_BIT] && rd_data[TOG_A_BIT])); // R6
    AST_SUSP_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == OP_SUSPEND) && !in_sect && !susp_prog) |-> (rd_data == array_data)); // R7
    AST_PROG_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_pulse && (mode == OP_PROGRAM)) |=> $stable(tog_q[1])); // R5
endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
    localparam int DW = 16, AW = 20, SW = 8, SETTLE = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op_mode = 2'd0;
    logic          susp_prog = 1'b0;
    logic [SW-1:0] susp_sector = 8'h5A;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_strobe = 1'b0;
    logic [DW-1:0] array_data = '0;
    logic [DW-1:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    logic m_a = 1'b0, m_b = 1'b0;   // model of the bit-6 / bit-2 toggles

    flash_status_gen #(.DATA_W(DW), .ADDR_W(AW), .SECT_W(SW), .SETTLE_CYCLES(SETTLE))
        u_flash_status_gen (.*);

    always #4 clk = ~clk;   // 125 MHz

    initial begin
        #(8 * 190000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic logic [DW-1:0] expect_word(logic [1:0] md, logic sp, logic ins,
                                                  logic [DW-1:0] d, logic a, logic b);
        logic [DW-1:0] w = d;
        case (md)
            2'd1: begin w[7] = ~d[7]; w[6] = a; end
            2'd2: begin w[7] = 1'b0; w[6] = a; w[2] = b; end
            2'd3: if (ins) begin w[7] = 1'b1; w[6] = 1'b1; w[2] = b; end
                  else if (sp) begin w[7] = ~d[7]; w[6] = a; end
            default: ;
        endcase
        return w;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One read: raise strobe, sample a cycle later, drop strobe, update the model.
    task automatic do_read(string req, logic [1:0] md, logic sp, logic ins, logic [DW-1:0] d);
        logic [AW-1:0] ad = AW'($urandom);
        if (ins) ad[AW-1 -: SW] = susp_sector;
        else if (ad[AW-1 -: SW] == susp_sector) ad[AW-1 -: SW] = susp_sector + 1'b1;
        @(negedge clk);
        op_mode = md; susp_prog = sp; rd_addr = ad; array_data = d; rd_strobe = 1'b1;
        @(negedge clk);
        check(req, rd_data, expect_word(md, sp, ins, d, m_a, m_b));
        rd_strobe = 1'b0;
        if (md == 2'd1 || md == 2'd2 || (md == 2'd3 && sp && !ins)) m_a = ~m_a;
        if (md == 2'd2 || (md == 2'd3 && ins)) m_b = ~m_b;
        @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, idle read is plain
        do_read("R1", 2'd0, 1'b0, 1'b0, 16'hA5C3);
        // R2 / R4 / R5: program reads, bit 6 toggles, bit 2 true
        do_read("R2", 2'd1, 1'b0, 1'b0, 16'h0084);
        do_read("R4", 2'd1, 1'b0, 1'b0, 16'hFF7B);
        do_read("R5", 2'd1, 1'b0, 1'b0, 16'h0004);
        // R3 / R5: erase reads, bit 2 toggles
        do_read("R3", 2'd2, 1'b0, 1'b0, 16'hFFFF);
        do_read("R5", 2'd2, 1'b0, 1'b0, 16'h0000);
        // R6: suspended sector
        do_read("R6", 2'd3, 1'b0, 1'b1, 16'h0000);
        do_read("R6", 2'd3, 1'b1, 1'b1, 16'h1234);
        // R7: plain data outside the sector, toggles must hold (next reads show them)
        do_read("R7", 2'd3, 1'b0, 1'b0, 16'hBEEF);
        do_read("R7", 2'd3, 1'b0, 1'b0, 16'h4044);
        // R8: program outside suspended sector
        do_read("R8", 2'd3, 1'b1, 1'b0, 16'h0080);
        do_read("R8", 2'd3, 1'b1, 1'b0, 16'h0004);
        // R10: toggles resume from held values
        do_read("R10", 2'd2, 1'b0, 1'b0, 16'h0F0F);
        do_read("R10", 2'd1, 1'b0, 1'b0, 16'hF0F0);

        // R9: settle window after program completes
        @(negedge clk);
        op_mode = 2'd1; rd_strobe = 1'b0;
        repeat (2) @(negedge clk);
        d = 16'h3C81;
        op_mode = 2'd0; array_data = d; rd_strobe = 1'b1;
        #1 check("R9", rd_data, {~d[15:8], d[7], ~d[6:0]});
        for (int m = 1; m <= SETTLE + 1; m++) begin
            @(posedge clk); @(negedge clk);
            if (m <= SETTLE) check("R9", rd_data, {~d[15:8], d[7], ~d[6:0]});
            else             check("R9", rd_data, d);
        end
        rd_strobe = 1'b0;
        // R9: erase completion opens the window too
        @(negedge clk); op_mode = 2'd2;
        @(negedge clk); op_mode = 2'd0; rd_strobe = 1'b1;
        @(negedge clk);
        check("R9", rd_data, {~d[15:8], d[7], ~d[6:0]});
        rd_strobe = 1'b0;
        repeat (SETTLE + 2) @(negedge clk);
        do_read("R1", 2'd0, 1'b0, 1'b0, 16'h7E11);

        // Random mix of busy modes (R2 R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < 400; i++) begin
            logic [1:0] md = 2'(1 + ($urandom % 3));
            do_read("R4_R5_mix", md, 1'($urandom), 1'($urandom), 16'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule